// File: doc/BRIEF.md
# Buffered SPI Master with In-Place Receive Buffer

This block is a memory-mapped SPI master built around one byte buffer. Software loads the outgoing bytes into the buffer, then writes a command to a 16-bit control/status register. The command gives the byte count and asks for a start. The engine clocks the bytes out in SPI mode 0, most significant bit first. Each byte received from the slave is written back into the buffer slot that held the byte just sent, so after completion the buffer holds the reply.

A flag in the command marks a fragment as the final one. The single chip select stays asserted between fragments that lack this flag, so one logical transfer can be longer than the buffer. When the marked fragment ends, chip select is released. A done flag is set at the end of every fragment. The flag is cleared by writing one to it, and it drives the interrupt output through an enable bit. A second 16-bit register sets the SCLK rate.

The bus is byte wide. Reads return data one cycle after the read strobe. A write to the high byte of the control register carries out the command. The low byte is only stored.

Top module: `spibm_top`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and irq is 0, and both control register bytes (addresses 1024 and 1025) read 0.
- R2: Address map: buffer bytes sit at addresses 0..1023. Address 1024 holds length[7:0]. Address 1025 is the control high byte: bits 1:0 are length[9:8], bit 3 is busy (read only), bit 4 is done (write 1 to clear), bit 5 is the interrupt enable, bit 6 is last and bit 7 is start. Addresses 1026 and 1027 hold the low and high bytes of the divider. A write to 1025 executes the command.
- R3: A start shifts `length` bytes, beginning at buffer byte 0 and going upward. Data is MSB first in SPI mode 0: sclk idles low, MOSI changes after falling edges, and MISO is sampled on rising edges.
- R4: Each received byte replaces the transmitted byte at the same buffer position.
- R5: A length field of 0 with start transfers 1024 bytes.
- R6: Inside a byte, each sclk high phase lasts divider+1 clock cycles. The divider is captured at start, so later writes do not affect a running fragment.
- R7: Chip select stays asserted after a fragment without the last bit. It is released when a fragment marked last ends.
- R8: A write to 1025 with last=1 and start=0 while idle deasserts cs_n at once.
- R9: The done flag is set when a fragment ends and is cleared by writing 1 to bit 4. irq equals done AND the enable.
- R10: The busy bit reads 1 while shifting. While busy, start commands and buffer writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 11 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
If the byte index is wrong, the shifted data goes out of order. The bench compares MOSI against expected values at the end of each byte, so this shows up within one byte time. If the chip-select state is wrong, cs_n is released too early or too late. That changes the number of bytes the bench slave counts in one select window, and cs_n is also checked one cycle after each fragment ends. Errors in the done or enable logic show at irq in the cycle after the event. Errors in the write-back path show when the buffer is read back after completion.

// File: rtl/spibm_pkg.sv
package spibm_pkg;
  localparam int BUF_BYTES_DEF = 1024;
  localparam int DIV_W_DEF     = 16;

  typedef enum logic [1:0] {E_IDLE, E_LOAD, E_SHIFT} eng_st_e;

  // Control high-byte bit positions
  localparam int CB_BUSY  = 3;
  localparam int CB_DONE  = 4;
  localparam int CB_IEN   = 5;
  localparam int CB_LAST  = 6;
  localparam int CB_START = 7;
endpackage

// File: rtl/spibm_ram.sv
module spibm_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_a,
  output logic [7:0]    rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [7:0]    rd_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/spibm_engine.sv
module spibm_engine
  import spibm_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int DIV_W = 16,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frag_len,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             fin,
  output logic [LEN_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [LEN_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  eng_st_e          st;
  logic [CNT_W-1:0] idx, total;
  logic [DIV_W-1:0] div_q, hc;
  logic [2:0]       bitc;
  logic [7:0]       sh, rx;
  logic             half_end, byte_end;

  assign half_end = (st == E_SHIFT) && (hc == div_q);
  assign byte_end = half_end && sclk && (bitc == 3'd7);

  assign busy    = (st != E_IDLE);
  assign mosi    = sh[7];
  assign rd_addr = idx[LEN_W-1:0];
  assign wr_en   = byte_end;
  assign wr_addr = idx[LEN_W-1:0];
  assign wr_data = rx;
  assign fin     = byte_end && ((idx + 1'b1) == total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; idx <= '0; total <= '0; div_q <= '0; hc <= '0;
      bitc <= '0; sh <= '0; rx <= '0; sclk <= 1'b0;
    end else begin
      unique case (st)
        E_IDLE: if (start) begin
          idx <= '0; total <= frag_len; div_q <= div; st <= E_LOAD;
        end
        E_LOAD: begin
          sh <= rd_data; bitc <= '0; hc <= '0; st <= E_SHIFT;
        end
        E_SHIFT: begin
          if (half_end) begin
            hc   <= '0;
            sclk <= ~sclk;
            if (!sclk) rx <= {rx[6:0], miso};
            else if (byte_end) begin
              idx <= idx + 1'b1;
              st  <= fin ? E_IDLE : E_LOAD;
            end else begin
              bitc <= bitc + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spibm_top.sv
module spibm_top
  import spibm_pkg::*;
#(
  parameter int BUF_BYTES = BUF_BYTES_DEF,
  parameter int DIV_W     = DIV_W_DEF,
  localparam int LEN_W  = $clog2(BUF_BYTES),
  localparam int CNT_W  = LEN_W + 1,
  localparam int ADDR_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam logic [ADDR_W-1:0] A_CTL_LO = ADDR_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] A_CTL_HI = ADDR_W'(BUF_BYTES + 1);
  localparam logic [ADDR_W-1:0] A_DIV_LO = ADDR_W'(BUF_BYTES + 2);
  localparam logic [ADDR_W-1:0] A_DIV_HI = ADDR_W'(BUF_BYTES + 3);

  function automatic logic [CNT_W-1:0] frag_bytes(input logic [LEN_W-1:0] f);
    return (f == '0) ? CNT_W'(BUF_BYTES) : {1'b0, f};
  endfunction

  logic [7:0]       len_lo;
  logic [1:0]       len_hi;
  logic [DIV_W-1:0] div_q;
  logic             irq_en, done_q, last_q, cs_act;
  logic             eng_busy, frag_fin, start_go, cs_clear, hi_wr, buf_wr;
  logic [9:0]       len_field;

  logic             eng_wr_en;
  logic [LEN_W-1:0] eng_rd_addr, eng_wr_addr, ram_waddr;
  logic [7:0]       eng_rd_data, eng_wr_data, ram_wdata, bus_buf_data;

  assign hi_wr     = bus_we && (bus_addr == A_CTL_HI);
  assign start_go  = hi_wr && bus_wdata[CB_START] && !eng_busy;
  assign cs_clear  = hi_wr && !bus_wdata[CB_START] && bus_wdata[CB_LAST] && !eng_busy;
  assign buf_wr    = bus_we && (bus_addr < A_CTL_LO) && !eng_busy;
  assign len_field = {bus_wdata[1:0], len_lo};

  assign ram_waddr = eng_wr_en ? eng_wr_addr : bus_addr[LEN_W-1:0];
  assign ram_wdata = eng_wr_en ? eng_wr_data : bus_wdata;

  spibm_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk(clk), .we(eng_wr_en | buf_wr), .waddr(ram_waddr), .wdata(ram_wdata),
    .ra_a(eng_rd_addr), .rd_a(eng_rd_data),
    .ra_b(bus_addr[LEN_W-1:0]), .rd_b(bus_buf_data)
  );

  spibm_engine #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_go),
    .frag_len(frag_bytes(len_field[LEN_W-1:0])), .div(div_q), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(eng_busy), .fin(frag_fin),
    .rd_addr(eng_rd_addr), .rd_data(eng_rd_data),
    .wr_en(eng_wr_en), .wr_addr(eng_wr_addr), .wr_data(eng_wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_lo <= '0; len_hi <= '0; div_q <= '0;
      irq_en <= 1'b0; done_q <= 1'b0; last_q <= 1'b0; cs_act <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_CTL_LO) len_lo <= bus_wdata;
      if (bus_we && bus_addr == A_DIV_LO) div_q[7:0] <= bus_wdata;
      if (bus_we && bus_addr == A_DIV_HI) div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
      if (hi_wr) begin
        irq_en <= bus_wdata[CB_IEN];
        if (bus_wdata[CB_DONE]) done_q <= 1'b0;
      end
      if (start_go) begin
        len_hi <= bus_wdata[1:0];
        last_q <= bus_wdata[CB_LAST];
        cs_act <= 1'b1;
      end
      if (cs_clear) cs_act <= 1'b0;
      if (frag_fin) begin
        done_q <= 1'b1;
        if (last_q) cs_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      if (bus_addr < A_CTL_LO) bus_rdata <= bus_buf_data;
      else if (bus_addr == A_CTL_LO) bus_rdata <= len_lo;
      else if (bus_addr == A_CTL_HI)
        bus_rdata <= {1'b0, last_q, irq_en, done_q, eng_busy, 1'b0, len_hi};
      else if (bus_addr == A_DIV_LO) bus_rdata <= div_q[7:0];
      else if (bus_addr == A_DIV_HI) bus_rdata <= div_q[DIV_W-1:8];
      else bus_rdata <= '0;
    end
  end

  assign cs_n = ~cs_act;
  assign irq  = done_q & irq_en;
endmodule

// File: rtl/spibm_chk.sv
module spibm_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic irq,
  input logic eng_busy,
  input logic frag_fin,
  input logic last_q,
  input logic done_q,
  input logic irq_en
);
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R3
  AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !eng_busy |-> !sclk); // R3
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n) eng_busy |-> !cs_n); // R7
  AST_LAST_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n) (frag_fin && last_q) |=> cs_n); // R7
  AST_NONLAST_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n) (frag_fin && !last_q) |=> !cs_n); // R7
  AST_FIN_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n) frag_fin |=> done_q); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R9
endmodule

bind spibm_top spibm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .irq(irq),
  .eng_busy(eng_busy), .frag_fin(frag_fin), .last_q(last_q),
  .done_q(done_q), .irq_en(irq_en)
);

// File: tb/spibm_top_tb.sv
module spibm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq, sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  byte unsigned exp_mosi[$];
  byte unsigned slave_q[$];

  always #10 clk = ~clk;

  spibm_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Slave model and MOSI monitor (scoreboard consumer)
  byte unsigned cur, rxs;
  int bitn = 0, sess = 0, last_sess = 0;
  always @(negedge cs_n) begin
    bitn = 0; sess = 0;
    cur = (slave_q.size() > 0) ? slave_q.pop_front() : 8'h00;
    miso = cur[7];
  end
  always @(posedge cs_n) last_sess = sess;
  always @(posedge sclk) if (!cs_n) begin
    rxs = {rxs[6:0], mosi};
    bitn++;
    if (bitn == 8) begin
      bitn = 0; sess++;
      if (exp_mosi.size() == 0) chk("R3 R10 unexpected byte", rxs, 256);
      else chk("R3 mosi byte", rxs, exp_mosi.pop_front());
      cur = (slave_q.size() > 0) ? slave_q.pop_front() : 8'h00;
    end
  end
  always @(negedge sclk) if (!cs_n) miso = cur[7-bitn];

  // SCLK high-phase length monitor
  int hp_cnt = 0, hp_high = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (sclk != sclk_prev) begin
      if (sclk_prev) hp_high = hp_cnt;
      hp_cnt = 1;
    end else hp_cnt++;
    sclk_prev = sclk;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_addr = 11'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); bus_addr = 11'(a); bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 60000 && !irq; k++) @(negedge clk);
  endtask

  task automatic wait_done();
    int v = 0;
    for (int k = 0; k < 20000; k++) begin
      rd(1025, v);
      if (v[4]) break;
    end
  endtask

  // driver: load a buffer byte and push its expected MOSI image
  task automatic put(input int i, input int d);
    wr(i, d); exp_mosi.push_back(8'(d));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    byte unsigned tx1[4] = '{8'h3C, 8'h81, 8'hF0, 8'h5A};
    byte unsigned sl1[4] = '{8'hA1, 8'h0F, 8'h77, 8'hC3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 irq", irq, 0);
    rd(1024, v); chk("R1 ctl lo", v, 0);
    rd(1025, v); chk("R1 ctl hi", v, 0);

    // T1: 4 bytes, div=1, last, irq enabled
    wr(1026, 1); wr(1027, 0);
    rd(1026, v); chk("R2 divider readback", v, 1);
    foreach (tx1[i]) begin put(i, tx1[i]); slave_q.push_back(sl1[i]); end
    wr(1024, 4); wr(1025, 8'hE0);
    rd(1025, v); chk("R10 busy bit", (v >> 3) & 1, 1);
    chk("R7 cs asserted while shifting", cs_n, 0);
    wr(3, 8'hEE);               // R10 buffer write ignored while busy
    wr(1025, 8'hE0);            // R10 start ignored while busy
    wr(1026, 5);                // R6 divider change not used by running fragment
    wait_irq();
    @(negedge clk);
    chk("R9 irq after done", irq, 1);
    chk("R7 cs released after last", cs_n, 1);
    chk("R6 high phase div=1", hp_high, 2);
    chk("R10 no extra bytes", exp_mosi.size(), 0);
    chk("R7 select window bytes", last_sess, 4);
    foreach (sl1[i]) begin rd(i, v); chk("R4 rx in place", v, sl1[i]); end
    rd(1025, v); chk("R9 done bit", (v >> 4) & 1, 1);
    wr(1025, 8'h30);
    chk("R9 irq cleared by W1C", irq, 0);

    // T2: non-last fragment then last fragment, irq masked, div=5
    slave_q.push_back(8'h11); slave_q.push_back(8'h22); slave_q.push_back(8'h33);
    put(0, 8'h40); put(1, 8'h41);
    wr(1024, 2); wr(1025, 8'h80);
    wait_done();
    chk("R9 irq masked", irq, 0);
    chk("R7 cs held after non-last", cs_n, 0);
    chk("R6 high phase div=5", hp_high, 6);
    wr(1025, 8'h10);
    put(0, 8'h99);
    wr(1024, 1); wr(1025, 8'hC0);
    wait_done();
    @(negedge clk);
    chk("R7 cs released after last", cs_n, 1);
    chk("R7 one select window for 3 bytes", last_sess, 3);
    rd(0, v); chk("R4 rx in place", v, 8'h33);
    wr(1025, 8'h10);

    // T3: last-only command deasserts cs (R8)
    slave_q.push_back(8'h5E);
    put(0, 8'h0F);
    wr(1024, 1); wr(1025, 8'h80);
    wait_done();
    chk("R8 cs still held", cs_n, 0);
    wr(1025, 8'h50);
    chk("R8 cs released by last-only write", cs_n, 1);
    wr(1025, 8'h00);
    chk("R8 cs stays released", cs_n, 1);

    // T4: length 0 means 1024 bytes, div=0 (R5)
    wr(1026, 0); wr(1027, 0);
    for (int i = 0; i < 1024; i++) begin
      put(i, (i * 13 + 7) & 8'hFF);
      slave_q.push_back(8'((i * 5 + 1) & 8'hFF));
    end
    wr(1024, 0); wr(1025, 8'hE0);
    wait_irq();
    @(negedge clk);
    chk("R5 full buffer select window", last_sess, 1024);
    chk("R5 all bytes shifted", exp_mosi.size(), 0);
    chk("R6 high phase div=0", hp_high, 1);
    rd(0, v);    chk("R5 R4 byte 0", v, 1);
    rd(511, v);  chk("R5 R4 byte 511", v, (511 * 5 + 1) & 8'hFF);
    rd(1023, v); chk("R5 R4 byte 1023", v, (1023 * 5 + 1) & 8'hFF);
    wr(1025, 8'h10);
    chk("R9 irq off after clear and mask", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule